// File: doc/BRIEF.md
# Multi-Way Branch Resolver

This block takes the branch slots of one instruction bundle, up to three of them, and turns them into a single next-address decision in one clock. Each slot arrives with a valid bit, a qualifying predicate, a kind bit that selects a direct target or an indirect one, a call bit, a signed displacement and a branch register index. A slot is active when it is valid and its predicate is true. The active slot with the lowest index wins. Its target becomes the next address. If no slot is active, the next address is the fall-through address, which is supplied from outside.

A direct target is the bundle address plus the sign-extended displacement scaled by 16. An indirect target comes from one of eight 64-bit branch registers and has its low four bits cleared so that it stays bundle-aligned. The block holds the branch registers itself and provides a write port for them. When the winning slot is marked as a call, the block raises a call flag and passes the fall-through address out as the link value.

The result is registered. It is visible on the outputs after the clock edge that samples the slot inputs.

Top module: `mwb_resolver`

## Requirements
- R1: When more than one slot is active, the active slot with the lowest index wins. `br_slot` reports that index (0, 1 or 2), and `br_target` is that slot's target.
- R2: A slot is active only when both its `slot_valid` bit and its `slot_pred` bit are 1. A slot whose valid bit is 0 never wins, whatever its predicate, kind, call bit or target.
- R3: For a direct slot (`slot_indirect` bit 0), the target is `bundle_pc + sext(disp) * 16`, computed modulo 2^64. The 21-bit displacement of slot i sits in bits [21*i+20 : 21*i] of `slot_disp`.
- R4: For an indirect slot (`slot_indirect` bit 1), the target is the branch register selected by the 3-bit index in bits [3*i+2 : 3*i] of `slot_breg`, with bits [3:0] forced to zero.
- R5: When no slot is active, `br_taken` is 0, `br_slot` is 3 and `br_target` equals `fall_thru`. Otherwise `br_taken` is 1.
- R6: When the winning slot has its `slot_call` bit set, `br_call` is 1 and `br_link` equals `fall_thru`. In every other case `br_call` is 0 and `br_link` is 0.
- R7: The outputs reflect the inputs sampled at the previous rising clock edge, so the latency is exactly one cycle.
- R8: A branch register write (`breg_we`, `breg_waddr`, `breg_wdata`) takes effect at the clock edge. A resolution sampled at that same edge still sees the old contents.
- R9: While `rst_n` is low, every branch register is cleared and the outputs read `br_taken`=0, `br_target`=0, `br_slot`=3, `br_call`=0 and `br_link`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| breg_we | input | 1 | Branch register write enable |
| breg_waddr | input | 3 | Branch register write index |
| breg_wdata | input | 64 | Branch register write data |
| bundle_pc | input | 64 | Address of the current bundle |
| fall_thru | input | 64 | Address used when no branch is taken; also the link value |
| slot_valid | input | 3 | Slot holds a branch, one bit per slot |
| slot_pred | input | 3 | Qualifying predicate per slot |
| slot_indirect | input | 3 | 1 = target comes from a branch register |
| slot_call | input | 3 | 1 = slot is a call |
| slot_disp | input | 63 | Three 21-bit signed displacements in units of 16 bytes |
| slot_breg | input | 9 | Three 3-bit branch register indices |
| br_taken | output | 1 | A slot won |
| br_target | output | 64 | Next bundle address |
| br_slot | output | 2 | Winning slot index, 3 for fall-through |
| br_call | output | 1 | Winning slot is a call |
| br_link | output | 64 | Return address for a call, else 0 |

## Verification
The block keeps no state between bundles apart from the branch registers and the output flops. A wrong priority, a wrong activity mask or a wrong target therefore shows up on `br_slot` or `br_target` one cycle after the bundle that provokes it. A corrupted branch register stays hidden until an indirect slot names that register and wins, and it then appears as a wrong target in that same one-cycle window. To expose such faults, the stimulus writes registers with random values, including values whose low bits are set, and then points indirect winners at them.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  parameter int ADDR_W  = 64;
  parameter int DISP_W  = 21;
  parameter int NSLOT   = 3;
  parameter int NBREG   = 8;
  parameter int ALIGN_B = 4;
  localparam int BIDX_W = $clog2(NBREG);
  localparam int SIDX_W = $clog2(NSLOT + 1);

  // Direct target: bundle address plus displacement scaled to bundles.
  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] pc,
                                                   input logic [DISP_W-1:0] disp);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    return pc + (ext << ALIGN_B);
  endfunction

  // Indirect target: clear the in-bundle offset bits.
  function automatic logic [ADDR_W-1:0] bundle_align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
  endfunction
endpackage

// File: rtl/mwb_breg_file.sv
module mwb_breg_file
  import mwb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [BIDX_W-1:0]       waddr,
  input  logic [ADDR_W-1:0]       wdata,
  input  logic [NSLOT*BIDX_W-1:0] raddr,
  output logic [NSLOT*ADDR_W-1:0] rdata
);
  logic [ADDR_W-1:0] regs [NBREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NBREG; k++) regs[k] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_rd
    assign rdata[s*ADDR_W +: ADDR_W] = regs[raddr[s*BIDX_W +: BIDX_W]];
  end
endmodule

// File: rtl/mwb_slot_target.sv
module mwb_slot_target
  import mwb_pkg::*;
(
  input  logic [ADDR_W-1:0]       pc,
  input  logic [NSLOT*DISP_W-1:0] disp,
  input  logic [NSLOT-1:0]        indirect,
  input  logic [NSLOT*ADDR_W-1:0] breg_val,
  output logic [NSLOT*ADDR_W-1:0] tgt
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [ADDR_W-1:0] rel_t, ind_t;
    assign rel_t = rel_target(pc, disp[s*DISP_W +: DISP_W]);
    assign ind_t = bundle_align(breg_val[s*ADDR_W +: ADDR_W]);
    assign tgt[s*ADDR_W +: ADDR_W] = indirect[s] ? ind_t : rel_t;
  end
endmodule

// File: rtl/mwb_prio_pick.sv
module mwb_prio_pick
  import mwb_pkg::*;
(
  input  logic [NSLOT-1:0]  act,
  output logic [NSLOT-1:0]  win_oh,
  output logic [SIDX_W-1:0] win_idx,
  output logic              any
);
  always_comb begin
    win_oh  = '0;
    win_idx = SIDX_W'(NSLOT);
    any     = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (act[i]) begin
        win_oh    = '0;
        win_oh[i] = 1'b1;
        win_idx   = SIDX_W'(i);
        any       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mwb_resolver.sv
module mwb_resolver
  import mwb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    breg_we,
  input  logic [BIDX_W-1:0]       breg_waddr,
  input  logic [ADDR_W-1:0]       breg_wdata,
  input  logic [ADDR_W-1:0]       bundle_pc,
  input  logic [ADDR_W-1:0]       fall_thru,
  input  logic [NSLOT-1:0]        slot_valid,
  input  logic [NSLOT-1:0]        slot_pred,
  input  logic [NSLOT-1:0]        slot_indirect,
  input  logic [NSLOT-1:0]        slot_call,
  input  logic [NSLOT*DISP_W-1:0] slot_disp,
  input  logic [NSLOT*BIDX_W-1:0] slot_breg,
  output logic                    br_taken,
  output logic [ADDR_W-1:0]       br_target,
  output logic [SIDX_W-1:0]       br_slot,
  output logic                    br_call,
  output logic [ADDR_W-1:0]       br_link
);
  logic [NSLOT*ADDR_W-1:0] breg_val;
  logic [NSLOT*ADDR_W-1:0] slot_tgt;
  logic [NSLOT-1:0]        act, win_oh;
  logic [SIDX_W-1:0]       win_idx;
  logic                    win_any;
  logic [ADDR_W-1:0]       next_tgt;
  logic                    next_call;
  logic                    out_live;

  assign act = slot_valid & slot_pred;

  mwb_breg_file u_bregs (
    .clk(clk), .rst_n(rst_n), .we(breg_we), .waddr(breg_waddr),
    .wdata(breg_wdata), .raddr(slot_breg), .rdata(breg_val)
  );

  mwb_slot_target u_tgt (
    .pc(bundle_pc), .disp(slot_disp), .indirect(slot_indirect),
    .breg_val(breg_val), .tgt(slot_tgt)
  );

  mwb_prio_pick u_pick (
    .act(act), .win_oh(win_oh), .win_idx(win_idx), .any(win_any)
  );

  always_comb begin
    next_tgt  = fall_thru;
    next_call = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (win_oh[i]) begin
        next_tgt  = slot_tgt[i*ADDR_W +: ADDR_W];
        next_call = slot_call[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_taken  <= 1'b0;
      br_target <= '0;
      br_slot   <= SIDX_W'(NSLOT);
      br_call   <= 1'b0;
      br_link   <= '0;
      out_live  <= 1'b0;
    end else begin
      br_taken  <= win_any;
      br_target <= next_tgt;
      br_slot   <= win_idx;
      br_call   <= next_call;
      br_link   <= next_call ? fall_thru : '0;
      out_live  <= 1'b1;
    end
  end

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh)); // R1
  AST_WIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_oh & ~(slot_valid & slot_pred)) == '0); // R2
  AST_TAKEN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken == (br_slot != SIDX_W'(NSLOT))); // R5
  AST_FT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && !br_taken) |-> br_target == $past(fall_thru)); // R5
  AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_live && br_call) |-> (br_taken && br_link == $past(fall_thru))); // R6
  AST_NOCALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    !br_call |-> br_link == '0); // R6
endmodule

// File: tb/mwb_resolver_bench.sv
module mwb_resolver_bench;
  import mwb_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic breg_we = 1'b0;
  logic [BIDX_W-1:0] breg_waddr = '0;
  logic [ADDR_W-1:0] breg_wdata = '0;
  logic [ADDR_W-1:0] bundle_pc = '0, fall_thru = '0;
  logic [NSLOT-1:0] slot_valid = '0, slot_pred = '0, slot_indirect = '0, slot_call = '0;
  logic [NSLOT*DISP_W-1:0] slot_disp = '0;
  logic [NSLOT*BIDX_W-1:0] slot_breg = '0;
  logic br_taken, br_call;
  logic [ADDR_W-1:0] br_target, br_link;
  logic [SIDX_W-1:0] br_slot;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [ADDR_W-1:0] model_breg [NBREG];
  logic e_taken, e_call;
  logic [ADDR_W-1:0] e_target, e_link;
  logic [1:0] e_slot;

  always #5 clk = ~clk;

  mwb_resolver u_mwb_resolver (.*);

  task automatic chk(input string req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: arithmetic as multiply on signed values.
  function automatic logic [ADDR_W-1:0] model_tgt(input int s);
    longint signed d;
    logic [ADDR_W-1:0] r;
    if (slot_indirect[s]) begin
      r = model_breg[slot_breg[s*BIDX_W +: BIDX_W]];
      return r - (r % 16);
    end
    d = longint'($signed(slot_disp[s*DISP_W +: DISP_W]));
    return bundle_pc + ADDR_W'(d * 16);
  endfunction

  task automatic compute_expected();
    e_taken = 0; e_call = 0; e_target = fall_thru; e_link = '0; e_slot = 2'd3;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (slot_valid[s] == 1'b1 && slot_pred[s] == 1'b1) begin
        e_taken = 1; e_slot = 2'(s); e_target = model_tgt(s); e_call = slot_call[s];
      end
    end
    if (e_call) e_link = fall_thru;
  endtask

  // Inputs already set before the negedge-aligned call; result checked after next posedge.
  task automatic step(input string tag);
    compute_expected();
    if (breg_we) model_breg[breg_waddr] = breg_wdata;  // R8: new value after the edge
    @(posedge clk); #1;
    chk({tag, " R5 taken"}, ADDR_W'(br_taken), ADDR_W'(e_taken));
    chk({tag, " R1 slot"}, ADDR_W'(br_slot), ADDR_W'(e_slot));
    chk({tag, " R3/R4 target"}, br_target, e_target);
    chk({tag, " R6 call"}, ADDR_W'(br_call), ADDR_W'(e_call));
    chk({tag, " R6 link"}, br_link, e_link);
    @(negedge clk);
    breg_we = 1'b0;
  endtask

  task automatic set_slot(input int s, input bit v, input bit p, input bit ind, input bit c,
                          input logic [DISP_W-1:0] d, input logic [BIDX_W-1:0] b);
    slot_valid[s] = v; slot_pred[s] = p; slot_indirect[s] = ind; slot_call[s] = c;
    slot_disp[s*DISP_W +: DISP_W] = d; slot_breg[s*BIDX_W +: BIDX_W] = b;
  endtask

  task automatic write_breg(input int idx, input logic [ADDR_W-1:0] val);
    breg_we = 1'b1; breg_waddr = BIDX_W'(idx); breg_wdata = val;
    slot_valid = '0;
    step("bregwr");
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int k = 0; k < NBREG; k++) model_breg[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 taken", ADDR_W'(br_taken), '0);
    chk("R9 target", br_target, '0);
    chk("R9 slot", ADDR_W'(br_slot), 64'd3);
    chk("R9 call", ADDR_W'(br_call), '0);
    chk("R9 link", br_link, '0);
    @(negedge clk); rst_n = 1'b1;

    bundle_pc = 64'h0000_1000_0000_2000; fall_thru = 64'h0000_1000_0000_2010;
    // R2: invalid slots with true predicates are ignored -> fall-through
    set_slot(0, 0, 1, 0, 1, 21'd5, 3'd0);
    set_slot(1, 0, 1, 1, 1, 21'd9, 3'd1);
    set_slot(2, 0, 1, 0, 0, 21'd7, 3'd2);
    step("R2 invalid");
    // R5: valid but predicates false
    slot_valid = 3'b111; slot_pred = 3'b000;
    step("R5 nopred");
    // R1: all active -> slot 0
    slot_pred = 3'b111;
    step("R1 all");
    // R1/R2: slot0 invalid, 1 and 2 active -> slot 1 (call, indirect)
    slot_valid = 3'b110;
    write_breg(1, 64'hDEAD_BEEF_CAFE_F00F);  // R4 low bits set
    slot_valid = 3'b110;
    step("R4 indirect call");
    // R3: negative displacement on slot 2
    set_slot(0, 1, 0, 0, 0, 21'd1, 3'd0);
    set_slot(1, 1, 0, 0, 0, 21'd1, 3'd0);
    set_slot(2, 1, 1, 0, 0, 21'h1FFFFF, 3'd0);
    step("R3 negdisp");
    set_slot(2, 1, 1, 0, 0, 21'h100000, 3'd0);
    step("R3 mostneg");
    // R8: write and read same register in one cycle -> old value, then new
    set_slot(0, 1, 1, 1, 0, 21'd0, 3'd3);
    breg_we = 1'b1; breg_waddr = 3'd3; breg_wdata = 64'h1234_5678_9ABC_DEF7;
    step("R8 same-cycle");
    step("R8 next-cycle");

    // Constrained random mix; R7 one-cycle latency checked on every step
    for (int n = 0; n < 400; n++) begin
      bundle_pc = {$urandom, $urandom} & ~64'hF;
      fall_thru = bundle_pc + 64'h10;
      slot_valid = 3'($urandom); slot_pred = 3'($urandom);
      slot_indirect = 3'($urandom); slot_call = 3'($urandom);
      slot_disp = {$urandom, $urandom};
      slot_breg = 9'($urandom);
      breg_we = ($urandom % 3) == 0;
      breg_waddr = 3'($urandom); breg_wdata = {$urandom, $urandom};
      step("R7 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200_000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule